// File: doc/BRIEF.md
# Dual Cascadable Countdown Timer

Two 8-bit down-counters share one control word and one programmable prescaler. Each timer takes its count pulse from one of four single-cycle tick sources: two fixed-rate tick enables, the prescaler's output pulse, or (for the second timer only) the first timer's underflow. When a timer steps past a count of one, it reloads its divisor in the same cycle and raises a sticky interrupt flag. Software clears that flag through the same control word.

Software programs a timer in two writes. The first write uses hold mode, which loads the divisor into the counter and freezes it. The second write uses run mode with the same divisor. Elapsed ticks in the current period are the divisor minus the readable count. With the second timer chained to the first, the pair forms one wider counter. The prescaler has a writable reload value and a readable count. It runs on every clock and wraps without regard to the timers.

Top module: `cascade_timer`

## Requirements
- R1: After reset both counts, both interrupt flags, the prescaler count and the prescaler reload are 0, and both timers are in hold mode with source 0.
- R2: The control word carries one 12-bit field per timer, with timer 0 in bits [11:0] and timer 1 in bits [23:12]. Inside each field, bits [7:0] hold the divisor, bit 8 the mode (0 hold, 1 run), bit 9 the interrupt action (0 no-op, 1 clear) and bits [11:10] the tick source.
- R3: A control write with mode hold makes the timer's count equal the written divisor from the next cycle on. The count then stays unchanged until a later write.
- R4: In run mode the count drops by one on each selected tick. A tick at count 1 is an underflow: it reloads the stored divisor in that cycle, so a divisor of D gives one underflow every D ticks. With a tick every 4 cycles and D = 250, underflows come 1000 cycles apart.
- R5: A divisor of 0 gives a period of 256 ticks.
- R6: Source code 0 selects fixed tick A (fix_tick_i[0]), 1 selects fixed tick B (fix_tick_i[1]), 2 selects the prescaler pulse and 3 selects timer 0's underflow, taken in the same cycle. Timer 0 with code 3 never counts.
- R7: An underflow sets that timer's interrupt flag from the next cycle. The flag stays set until it is cleared.
- R8: A control write whose action is clear drops that timer's flag in the next cycle. A write with action no-op leaves the flag unchanged.
- R9: When a clear write and an underflow of the same timer fall in the same cycle, the flag stays set.
- R10: A prescaler write loads both the reload value and the count. On every other cycle the count drops by one, except that at a count of 1 or 0 it emits a pulse and reloads. A reload value of R gives one pulse every max(R,1) cycles.
- R11: A control write with mode run leaves the count untouched. The new divisor is used only at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 24 | Control word, two per-timer fields |
| presc_we_i | input | 1 | Prescaler reload write strobe |
| presc_wdata_i | input | 16 | Prescaler reload value |
| fix_tick_i | input | 2 | Fixed-rate tick enables A (bit 0) and B (bit 1) |
| presc_cnt_o | output | 16 | Current prescaler count |
| tmr_cnt_o | output | 16 | Timer counts, timer 0 in [7:0], timer 1 in [15:8] |
| irq_o | output | 2 | Sticky interrupt flags, one per timer |

## Verification
Some properties are checked on every cycle. These are: the reload of the divisor on underflow, the flag set on underflow, the flag holding when no clear arrives, the frozen count in hold mode, and the prescaler count never exceeding its reload. Other behaviour only shows over many cycles, and the bench's scenarios cover it. These are the period lengths (250 ticks, 256 for a zero divisor, the 48-cycle chained period, the prescaler-driven period), the clear that collides with an underflow, a chained source selected on timer 0, and a run write that leaves the count alone. A behavioural model compares all outputs on every clock.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned N_TMR = 2;
  localparam int unsigned N_SRC = 4;

  typedef enum logic {MODE_HOLD = 1'b0, MODE_RUN = 1'b1} tmr_mode_e;
  typedef enum logic {ACT_NOP = 1'b0, ACT_CLR = 1'b1} tmr_act_e;
  typedef enum logic [1:0] {
    SRC_FIX_A = 2'd0,
    SRC_FIX_B = 2'd1,
    SRC_PRESC = 2'd2,
    SRC_CHAIN = 2'd3
  } tmr_src_e;

  // field order fixes the bit layout of the control word
  typedef struct packed {
    tmr_src_e         src;
    tmr_act_e         act;
    tmr_mode_e        mode;
    logic [CNT_W-1:0] div;
  } tmr_cfg_t;

  localparam int unsigned CFG_W = $bits(tmr_cfg_t);
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int unsigned PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] reload_i,
  output logic          tick_o,
  output logic [PW-1:0] cnt_o
);
  logic [PW-1:0] reload_q, cnt_q, cnt_d;

  assign tick_o = (cnt_q <= PW'(1));

  always_comb begin
    if (we_i)        cnt_d = reload_i;
    else if (tick_o) cnt_d = reload_q;
    else             cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (we_i) reload_q <= reload_i;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R10
  presc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= reload_q);

  // R10
  presc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !we_i) |=> (cnt_q == $past(reload_q)));
endmodule

// File: rtl/ct_timer_unit.sv
module ct_timer_unit
  import cascade_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  tmr_cfg_t         cfg_i,
  input  logic [N_SRC-1:0] src_i,
  output logic             uf_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] div_q, cnt_q, cnt_d;
  tmr_mode_e        mode_q;
  tmr_src_e         src_q;
  logic             irq_q;
  logic             tick, load, step, uf, clr;

  assign tick = src_i[src_q];
  assign load = cfg_we_i && (cfg_i.mode == MODE_HOLD);
  assign step = (mode_q == MODE_RUN) && tick && !load;
  assign uf   = step && (cnt_q == CNT_W'(1));
  assign clr  = cfg_we_i && (cfg_i.act == ACT_CLR);

  always_comb begin
    if (load)      cnt_d = cfg_i.div;
    else if (uf)   cnt_d = div_q;
    else if (step) cnt_d = cnt_q - CNT_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      mode_q <= MODE_HOLD;
      src_q  <= SRC_FIX_A;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        div_q  <= cfg_i.div;
        mode_q <= cfg_i.mode;
        src_q  <= cfg_i.src;
      end
      cnt_q <= cnt_d;
      irq_q <= uf | (irq_q & ~clr);  // underflow wins over clear
    end
  end

  assign uf_o  = uf;
  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  // R4
  reload_on_uf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf |=> (cnt_q == $past(div_q)));

  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf |=> irq_q);

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr) |=> irq_q);

  // R3
  hold_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_HOLD && !cfg_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import cascade_timer_pkg::*;
#(
  parameter int unsigned PRESC_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ctrl_we_i,
  input  logic [N_TMR*CFG_W-1:0] ctrl_wdata_i,
  input  logic                   presc_we_i,
  input  logic [PRESC_W-1:0]     presc_wdata_i,
  input  logic [1:0]             fix_tick_i,
  output logic [PRESC_W-1:0]     presc_cnt_o,
  output logic [N_TMR*CNT_W-1:0] tmr_cnt_o,
  output logic [N_TMR-1:0]       irq_o
);
  logic             flex_tick;
  logic [N_TMR-1:0] uf, chain;

  ct_prescaler #(.PW(PRESC_W)) i_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (presc_we_i),
    .reload_i (presc_wdata_i),
    .tick_o   (flex_tick),
    .cnt_o    (presc_cnt_o)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    tmr_cfg_t         cfg;
    logic [N_SRC-1:0] src;

    if (g == 0) begin : g_head
      assign chain[g] = 1'b0;
    end else begin : g_link
      assign chain[g] = uf[g-1];
    end

    assign cfg = tmr_cfg_t'(ctrl_wdata_i[g*CFG_W +: CFG_W]);
    assign src = {chain[g], flex_tick, fix_tick_i};

    ct_timer_unit i_unit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cfg_we_i (ctrl_we_i),
      .cfg_i    (cfg),
      .src_i    (src),
      .uf_o     (uf[g]),
      .cnt_o    (tmr_cnt_o[g*CNT_W +: CNT_W]),
      .irq_o    (irq_o[g])
    );
  end
endmodule

// File: tb/test_cascade_timer.sv
module test_cascade_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [23:0] ctrl_wdata = '0;
  logic        presc_we = 1'b0;
  logic [15:0] presc_wdata = '0;
  logic [1:0]  fix_tick = '0;
  logic [15:0] presc_cnt;
  logic [15:0] tmr_cnt;
  logic [1:0]  irq;

  int nvec = 0, nfail = 0, cyc = 0, fc = 0;
  bit done = 0;

  int m_cnt[2], m_div[2], m_run[2], m_sel[2], m_irq[2];
  int m_rel, m_pc;

  always #10 clk = ~clk;

  cascade_timer i_cascade_timer (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .presc_we_i(presc_we), .presc_wdata_i(presc_wdata), .fix_tick_i(fix_tick),
    .presc_cnt_o(presc_cnt), .tmr_cnt_o(tmr_cnt), .irq_o(irq)
  );

  // fixed ticks: A every 4 cycles, B every 3 cycles
  always @(negedge clk) begin
    fc <= fc + 1;
    fix_tick[0] <= (fc % 4 == 0);
    fix_tick[1] <= (fc % 3 == 0);
  end

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_div[i] = 0; m_run[i] = 0; m_sel[i] = 0; m_irq[i] = 0;
      end
      m_rel = 0; m_pc = 0;
    end else begin
      int flex, uf0;
      flex = (m_pc <= 1);
      uf0 = 0;
      for (int i = 0; i < 2; i++) begin
        int f, fdiv, fmode, fact, fsel, tk, ld, uf, clr;
        f     = (ctrl_wdata >> (12 * i)) & 'hfff;
        fdiv  = f & 255;
        fmode = (f >> 8) & 1;
        fact  = (f >> 9) & 1;
        fsel  = (f >> 10) & 3;
        case (m_sel[i])
          0: tk = fix_tick[0];
          1: tk = fix_tick[1];
          2: tk = flex;
          default: tk = (i == 1) ? uf0 : 0;
        endcase
        ld  = ctrl_we && (fmode == 0);
        uf  = !ld && m_run[i] && tk && (m_cnt[i] == 1);
        clr = ctrl_we && (fact == 1);
        if (ld) m_cnt[i] = fdiv;
        else if (uf) m_cnt[i] = m_div[i];
        else if (m_run[i] && tk) m_cnt[i] = (m_cnt[i] + 255) % 256;
        m_irq[i] = (uf || (m_irq[i] && !clr)) ? 1 : 0;
        if (ctrl_we) begin
          m_div[i] = fdiv; m_run[i] = fmode; m_sel[i] = fsel;
        end
        if (i == 0) uf0 = uf;
      end
      if (presc_we) begin
        m_rel = presc_wdata; m_pc = presc_wdata;
      end else if (m_pc <= 1) m_pc = m_rel;
      else m_pc = m_pc - 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 cnt0", tmr_cnt[7:0], m_cnt[0]);
      chk("R4 cnt1", tmr_cnt[15:8], m_cnt[1]);
      chk("R7 irq0", irq[0], m_irq[0]);
      chk("R7 irq1", irq[1], m_irq[1]);
      chk("R10 presc", presc_cnt, m_pc);
    end
  end

  function automatic logic [11:0] fld(int div, int mode, int act, int src);
    return {src[1:0], act[0], mode[0], div[7:0]};
  endfunction

  task automatic wr_ctrl(input logic [11:0] c0, input logic [11:0] c1);
    ctrl_we = 1'b1; ctrl_wdata = {c1, c0};
    @(negedge clk);
    ctrl_we = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic wr_presc(input int v);
    presc_we = 1'b1; presc_wdata = v[15:0];
    @(negedge clk);
    presc_we = 1'b0;
  endtask

  task automatic wait_irq(input int i, output int t);
    for (int k = 0; k < 5000; k++) begin
      if (irq[i]) break;
      @(negedge clk);
    end
    t = cyc;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int t1, t2, c;
    idle(3);
    // R1 reset state
    chk("R1 cnt", tmr_cnt, 0);
    chk("R1 irq", irq, 0);
    chk("R1 presc", presc_cnt, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 presc after release", presc_cnt, 0);

    // R3 R2: hold load, then frozen
    wr_ctrl(fld(250, 0, 0, 0), fld(5, 0, 0, 1));
    chk("R3 load t0", tmr_cnt[7:0], 250);
    chk("R3 load t1", tmr_cnt[15:8], 5);
    idle(20);
    chk("R3 hold t1", tmr_cnt[15:8], 5);

    // R4: 250 ticks of A (period 4) -> 1000 cycles
    wr_ctrl(fld(250, 1, 0, 0), fld(5, 0, 0, 1));
    wait_irq(0, t1);
    chk("R7 flag up", irq[0], 1);
    wr_ctrl(fld(250, 1, 0, 0), fld(5, 0, 0, 1));
    chk("R8 nop keeps", irq[0], 1);
    wr_ctrl(fld(250, 1, 1, 0), fld(5, 0, 0, 1));
    chk("R8 clear", irq[0], 0);
    wait_irq(0, t2);
    chk("R4 period 1000", t2 - t1, 1000);

    // R5: divisor 0 on source B (period 3) -> 768 cycles
    wr_ctrl(fld(0, 0, 1, 0), fld(0, 0, 0, 1));
    chk("R5 load zero", tmr_cnt[15:8], 0);
    wr_ctrl(fld(0, 0, 0, 0), fld(0, 1, 0, 1));
    wait_irq(1, t1);
    wr_ctrl(fld(0, 0, 0, 0), fld(0, 1, 1, 1));
    wait_irq(1, t2);
    chk("R5 period 768", t2 - t1, 768);

    // R6: chained, t0 div4 on A (16 cyc), t1 div3 on chain -> 48
    wr_ctrl(fld(4, 0, 1, 0), fld(3, 0, 1, 3));
    wr_ctrl(fld(4, 1, 0, 0), fld(3, 1, 0, 3));
    wait_irq(1, t1);
    wr_ctrl(fld(4, 1, 1, 0), fld(3, 1, 1, 3));
    wait_irq(1, t2);
    chk("R6 chain period 48", t2 - t1, 48);

    // R6: timer 0 on chain source never counts
    wr_ctrl(fld(7, 0, 1, 0), fld(3, 0, 1, 0));
    wr_ctrl(fld(7, 1, 0, 3), fld(3, 0, 0, 0));
    idle(30);
    chk("R6 t0 chain idle", tmr_cnt[7:0], 7);
    chk("R6 t0 no flag", irq[0], 0);

    // R10: prescaler reload 9, timer 0 div2 on prescaler -> 18
    wr_presc(9);
    chk("R10 presc load", presc_cnt, 9);
    wr_ctrl(fld(2, 0, 1, 2), fld(3, 0, 0, 0));
    wr_ctrl(fld(2, 1, 0, 2), fld(3, 0, 0, 0));
    wait_irq(0, t1);
    wr_ctrl(fld(2, 1, 1, 2), fld(3, 0, 0, 0));
    wait_irq(0, t2);
    chk("R10 presc period 18", t2 - t1, 18);

    // R9: clear colliding with underflow (tick every cycle)
    wr_presc(0);
    wr_ctrl(fld(2, 0, 1, 2), fld(3, 0, 0, 0));
    wr_ctrl(fld(2, 1, 0, 2), fld(3, 0, 0, 0));
    for (int k = 0; k < 20; k++) begin
      if (irq[0] && tmr_cnt[7:0] == 1) break;
      @(negedge clk);
    end
    wr_ctrl(fld(2, 1, 1, 2), fld(3, 0, 0, 0));
    chk("R9 clear vs underflow", irq[0], 1);
    chk("R9 reload", tmr_cnt[7:0], 2);
    wr_ctrl(fld(2, 1, 1, 2), fld(3, 0, 0, 0));
    chk("R8 clear no uf", irq[0], 0);

    // R11: run write keeps count
    wr_ctrl(fld(200, 0, 1, 2), fld(3, 0, 0, 0));
    wr_ctrl(fld(200, 1, 0, 2), fld(3, 0, 0, 0));
    idle(3);
    c = tmr_cnt[7:0];
    wr_ctrl(fld(50, 1, 0, 2), fld(3, 0, 0, 0));
    chk("R11 run write keeps count", tmr_cnt[7:0], c - 1);
    idle(200);
    chk("R11 new div at reload", tmr_cnt[7:0] <= 50, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule